// File: doc/BRIEF.md
# Bus Watchpoint Trigger Unit

This block sits beside a processor core and watches its instruction bus and its data bus on every clock. It holds a small set of independently programmed trigger slots. Each slot looks at one of the two buses, tests the current bus cycle against its own conditions, and when all of them hold it fires the debug actions selected for that slot. The actions are a halt request to the debug logic, a pulse on an external trigger pin for outside test equipment, switching a trace-enable level on or off, a single-cycle trace-sample strobe, and arming.

Arming gives a two-step sequence. A slot can be marked so that it stays inert until some slot has fired with the arm action, so event B is caught only after event A. The armed state is one sticky flag shared by all slots.

The buses are only observed and never stalled, so the bus inputs carry a valid strobe and no ready. A monitor has no means of back-pressure, and a cycle with its valid strobe low is never matched. Configuration is a plain write port with a slot index, a field select and a data word.

Top module: `wp_trigger_unit`

## Requirements
- R1: After reset every output is low, every slot is disabled and the armed flag is clear, so no bus activity fires anything until a slot is configured.
- R2: A slot fires only in a cycle where the valid strobe of its selected bus is high. Its actions appear on the outputs in the cycle after that bus cycle.
- R3: An address or data comparator in mode 2 matches when lo <= value <= hi as unsigned numbers, with both ends included. In mode 1 it matches when value == lo. In mode 0 or 3 it always passes.
- R4: All enabled conditions of a slot are ANDed. These are the address compare, the data compare, the read requirement (d_rd high) and the write requirement (d_wr high).
- R5: On a slot that watches the instruction bus, the data compare, read, write and armed-only settings are ignored. Such a slot fires on i_valid and its address compare alone.
- R6: The trace-sample action is produced only by data-bus slots. On an instruction-bus slot the sample bit has no effect.
- R7: A data-bus slot marked armed-only never fires while the armed flag is clear. The arm action sets the flag, and the flag takes effect from the cycle after the arming bus cycle.
- R8: The armed flag stays set across later bus cycles and is cleared by any configuration write, to any slot and any field.
- R9: trace_en is a level. A trace-on action sets it, a trace-off action clears it, and it otherwise holds. If both actions occur in the same cycle, trace-off wins.
- R10: halt_req, ext_trig and trace_sample are high for exactly the cycles that follow a bus cycle in which some slot fired with that action. When several slots fire together, their actions are ORed.
- R11: A configuration write stores cfg_wdata into the field given by cfg_sel of slot cfg_slot: 0 = control, 1 = address low, 2 = address high, 3 = data low, 4 = data high. The stored value applies from the next cycle. Control bits: 0 enable, 1 bus select (1 = data bus), 3:2 address mode, 5:4 data mode, 6 require read, 7 require write, 8 armed-only, 9 halt, 10 external trigger, 11 trace on, 12 trace off, 13 trace sample, 14 arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Instruction bus cycle valid |
| i_addr | input | 32 | Instruction bus address |
| d_valid | input | 1 | Data bus cycle valid |
| d_addr | input | 32 | Data bus address |
| d_data | input | 32 | Data bus data value |
| d_rd | input | 1 | Data bus read cycle |
| d_wr | input | 1 | Data bus write cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 2 | Slot index for the write |
| cfg_sel | input | 3 | Field select for the write |
| cfg_wdata | input | 32 | Configuration write data |
| halt_req | output | 1 | Halt request pulse |
| ext_trig | output | 1 | External trigger pulse |
| trace_en | output | 1 | Trace collection enable level |
| trace_sample | output | 1 | Trace sample strobe |

## Verification
On every cycle, the assertions check that each output pulse and each change of trace_en is preceded by a valid bus cycle. They also check that a trace-sample strobe always follows a valid data-bus cycle. Only the directed scenarios can show the rest, because each depends on a sequence of configuration writes and bus cycles with a known expected response. This covers the inclusive range edges, the ANDing of conditions, the ignored settings on instruction-bus slots, the arm-then-fire order with its one-cycle delay, the clearing of the armed flag, and trace-off winning over trace-on.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int CTRL_W = 15;

  typedef enum logic [1:0] {
    CMP_OFF   = 2'd0,
    CMP_EQ    = 2'd1,
    CMP_RANGE = 2'd2
  } cmp_mode_e;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_A_LO = 3'd1,
    SEL_A_HI = 3'd2,
    SEL_D_LO = 3'd3,
    SEL_D_HI = 3'd4
  } cfg_sel_e;

  // bit 0 is en, bit 14 is act_arm
  typedef struct packed {
    logic       act_arm;
    logic       act_sample;
    logic       act_toff;
    logic       act_ton;
    logic       act_ext;
    logic       act_halt;
    logic       armed_only;
    logic       need_wr;
    logic       need_rd;
    logic [1:0] d_mode;
    logic [1:0] a_mode;
    logic       bus_d;
    logic       en;
  } slot_ctrl_t;

  typedef struct packed {
    logic halt;
    logic ext;
    logic ton;
    logic toff;
    logic sample;
    logic arm;
  } act_t;
endpackage

// File: rtl/wp_range_cmp.sv
module wp_range_cmp #(
  parameter int W = 32
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] value,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  import wp_pkg::*;

  always_comb begin
    unique case (mode)
      CMP_EQ:    hit = (value == lo);
      CMP_RANGE: hit = (value >= lo) && (value <= hi);
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_slot.sv
module wp_slot #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             armed,
  input  logic             i_valid,
  input  logic [AW-1:0]    i_addr,
  input  logic             d_valid,
  input  logic [AW-1:0]    d_addr,
  input  logic [DW-1:0]    d_data,
  input  logic             d_rd,
  input  logic             d_wr,
  output wp_pkg::act_t     act
);
  import wp_pkg::*;

  slot_ctrl_t    ctrl_q;
  logic [AW-1:0] a_lo_q, a_hi_q;
  logic [DW-1:0] d_lo_q, d_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      a_lo_q <= '0;
      a_hi_q <= '0;
      d_lo_q <= '0;
      d_hi_q <= '0;
    end else if (wr_en) begin
      unique case (cfg_sel_e'(wr_sel))
        SEL_CTRL: ctrl_q <= slot_ctrl_t'(wr_data[CTRL_W-1:0]);
        SEL_A_LO: a_lo_q <= wr_data[AW-1:0];
        SEL_A_HI: a_hi_q <= wr_data[AW-1:0];
        SEL_D_LO: d_lo_q <= wr_data[DW-1:0];
        SEL_D_HI: d_hi_q <= wr_data[DW-1:0];
        default:  ;
      endcase
    end
  end

  logic          on_d;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic [1:0]    d_mode_eff;
  logic          a_hit, d_hit;

  assign on_d       = ctrl_q.bus_d;
  assign bus_valid  = on_d ? d_valid : i_valid;
  assign bus_addr   = on_d ? d_addr : i_addr;
  assign d_mode_eff = on_d ? ctrl_q.d_mode : CMP_OFF;

  wp_range_cmp #(.W(AW)) u_acmp (
    .mode(ctrl_q.a_mode), .value(bus_addr), .lo(a_lo_q), .hi(a_hi_q), .hit(a_hit)
  );
  wp_range_cmp #(.W(DW)) u_dcmp (
    .mode(d_mode_eff), .value(d_data), .lo(d_lo_q), .hi(d_hi_q), .hit(d_hit)
  );

  logic rd_ok, wr_ok, arm_ok, fire;
  assign rd_ok  = !on_d || !ctrl_q.need_rd || d_rd;
  assign wr_ok  = !on_d || !ctrl_q.need_wr || d_wr;
  assign arm_ok = !on_d || !ctrl_q.armed_only || armed;
  assign fire   = ctrl_q.en && bus_valid && a_hit && d_hit && rd_ok && wr_ok && arm_ok;

  always_comb begin
    act.halt   = fire && ctrl_q.act_halt;
    act.ext    = fire && ctrl_q.act_ext;
    act.ton    = fire && ctrl_q.act_ton;
    act.toff   = fire && ctrl_q.act_toff;
    act.sample = fire && ctrl_q.act_sample && on_d;
    act.arm    = fire && ctrl_q.act_arm;
  end
endmodule

// File: rtl/wp_action.sv
module wp_action #(
  parameter int NSLOT = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  wp_pkg::act_t [NSLOT-1:0]      acts,
  input  logic                          cfg_write,
  output logic                          armed,
  output logic                          halt_req,
  output logic                          ext_trig,
  output logic                          trace_en,
  output logic                          trace_sample
);
  import wp_pkg::*;

  act_t any;

  always_comb begin
    any = '0;
    for (int s = 0; s < NSLOT; s++) begin
      any = any | acts[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      halt_req     <= 1'b0;
      ext_trig     <= 1'b0;
      trace_en     <= 1'b0;
      trace_sample <= 1'b0;
    end else begin
      halt_req     <= any.halt;
      ext_trig     <= any.ext;
      trace_sample <= any.sample;
      if (any.toff)     trace_en <= 1'b0;
      else if (any.ton) trace_en <= 1'b1;
      if (cfg_write)    armed <= 1'b0;
      else if (any.arm) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/wp_trigger_unit.sv
module wp_trigger_unit #(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [AW-1:0]     i_addr,
  input  logic              d_valid,
  input  logic [AW-1:0]     d_addr,
  input  logic [DW-1:0]     d_data,
  input  logic              d_rd,
  input  logic              d_wr,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [2:0]        cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  output logic              halt_req,
  output logic              ext_trig,
  output logic              trace_en,
  output logic              trace_sample
);
  import wp_pkg::*;

  act_t [NSLOT-1:0] slot_act;
  logic             armed;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wp_slot #(.AW(AW), .DW(DW), .CFG_W(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && (cfg_slot == SLOT_W'(g))),
      .wr_sel(cfg_sel), .wr_data(cfg_wdata),
      .armed(armed),
      .i_valid(i_valid), .i_addr(i_addr),
      .d_valid(d_valid), .d_addr(d_addr), .d_data(d_data),
      .d_rd(d_rd), .d_wr(d_wr),
      .act(slot_act[g])
    );
  end

  wp_action #(.NSLOT(NSLOT)) u_action (
    .clk(clk), .rst_n(rst_n), .acts(slot_act), .cfg_write(cfg_we),
    .armed(armed), .halt_req(halt_req), .ext_trig(ext_trig),
    .trace_en(trace_en), .trace_sample(trace_sample)
  );
endmodule

// File: rtl/wp_checker.sv
module wp_checker (
  input logic clk,
  input logic rst_n,
  input logic i_valid,
  input logic d_valid,
  input logic halt_req,
  input logic ext_trig,
  input logic trace_en,
  input logic trace_sample
);
  // R2/R10: a halt pulse always follows a valid bus cycle
  a_r10_halt_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(i_valid || d_valid));

  // R2/R10: an external trigger pulse always follows a valid bus cycle
  a_r10_ext_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig |-> $past(i_valid || d_valid));

  // R6: a sample strobe can only come from a data-bus cycle
  a_r6_sample_from_dbus: assert property (@(posedge clk) disable iff (!rst_n)
    trace_sample |-> $past(d_valid));

  // R9: trace_en changes only after a valid bus cycle
  a_r9_trace_moves_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trace_en) |-> $past(i_valid || d_valid));
endmodule

bind wp_trigger_unit wp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .d_valid(d_valid),
  .halt_req(halt_req), .ext_trig(ext_trig), .trace_en(trace_en),
  .trace_sample(trace_sample)
);

// File: tb/test_wp_trigger_unit.sv
module test_wp_trigger_unit;
  // control bit values, see R11
  localparam logic [31:0] EN      = 32'h1;
  localparam logic [31:0] DBUS    = 32'h2;
  localparam logic [31:0] A_EQ    = 32'h4;
  localparam logic [31:0] A_RNG   = 32'h8;
  localparam logic [31:0] D_EQ    = 32'h10;
  localparam logic [31:0] D_RNG   = 32'h20;
  localparam logic [31:0] NRD     = 32'h40;
  localparam logic [31:0] NWR     = 32'h80;
  localparam logic [31:0] ARMONLY = 32'h100;
  localparam logic [31:0] HALT    = 32'h200;
  localparam logic [31:0] EXT     = 32'h400;
  localparam logic [31:0] TON     = 32'h800;
  localparam logic [31:0] TOFF    = 32'h1000;
  localparam logic [31:0] SAMP    = 32'h2000;
  localparam logic [31:0] ARM     = 32'h4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_valid = 1'b0;
  logic [31:0] i_addr = '0;
  logic        d_valid = 1'b0;
  logic [31:0] d_addr = '0;
  logic [31:0] d_data = '0;
  logic        d_rd = 1'b0;
  logic        d_wr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        halt_req, ext_trig, trace_en, trace_sample;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 4 ns period

  wp_trigger_unit i_wp_trigger_unit (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_addr(i_addr),
    .d_valid(d_valid), .d_addr(d_addr), .d_data(d_data), .d_rd(d_rd), .d_wr(d_wr),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .halt_req(halt_req), .ext_trig(ext_trig), .trace_en(trace_en),
    .trace_sample(trace_sample)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cfg(input int slot, input int sel, input logic [31:0] val);
    cfg_we = 1'b1; cfg_slot = 2'(slot); cfg_sel = 3'(sel); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_slots();
    for (int s = 0; s < 4; s++) cfg(s, 0, 32'h0);
  endtask

  // one bus cycle; returns at the negedge where its effect is visible
  task automatic bus(input logic iv, input logic [31:0] ia, input logic dv,
                     input logic [31:0] da, input logic [31:0] dd,
                     input logic rd, input logic wr);
    i_valid = iv; i_addr = ia; d_valid = dv; d_addr = da; d_data = dd;
    d_rd = rd; d_wr = wr;
    @(negedge clk);
    i_valid = 1'b0; d_valid = 1'b0; d_rd = 1'b0; d_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 halt after reset", halt_req, 1'b0);
    chk("R1 ext after reset", ext_trig, 1'b0);
    chk("R1 trace_en after reset", trace_en, 1'b0);
    chk("R1 sample after reset", trace_sample, 1'b0);
    bus(1, 32'h0, 1, 32'h0, 32'h0, 1, 1);
    chk("R1 unconfigured slots quiet", halt_req | ext_trig | trace_sample | trace_en, 1'b0);
  endtask

  task automatic t_addr_eq();
    clear_slots();
    cfg(0, 1, 32'h100);
    cfg(0, 0, EN | A_EQ | HALT);
    bus(1, 32'h100, 0, 0, 0, 0, 0);
    chk("R2 R11 instr address match halts", halt_req, 1'b1);
    idle();
    chk("R10 halt is one cycle", halt_req, 1'b0);
    bus(1, 32'h104, 0, 0, 0, 0, 0);
    chk("R2 other address no halt", halt_req, 1'b0);
    bus(0, 32'h100, 0, 0, 0, 0, 0);
    chk("R2 invalid cycle ignored", halt_req, 1'b0);
  endtask

  task automatic t_range();
    clear_slots();
    cfg(1, 1, 32'h200); cfg(1, 2, 32'h2FF);
    cfg(1, 0, EN | DBUS | A_RNG | EXT);
    bus(0, 0, 1, 32'h1FF, 0, 1, 0); chk("R3 below low end", ext_trig, 1'b0);
    bus(0, 0, 1, 32'h200, 0, 1, 0); chk("R3 low end inclusive", ext_trig, 1'b1);
    bus(0, 0, 1, 32'h2FF, 0, 1, 0); chk("R3 high end inclusive", ext_trig, 1'b1);
    bus(0, 0, 1, 32'h300, 0, 1, 0); chk("R3 above high end", ext_trig, 1'b0);
    bus(0, 0, 1, 32'hFFFF_0250, 0, 1, 0); chk("R3 unsigned compare", ext_trig, 1'b0);
    cfg(1, 3, 32'd10); cfg(1, 4, 32'd20);
    cfg(1, 1, 32'h40);
    cfg(1, 0, EN | DBUS | A_EQ | D_RNG | EXT);
    bus(0, 0, 1, 32'h40, 32'd20, 0, 1); chk("R3 data range hit", ext_trig, 1'b1);
    bus(0, 0, 1, 32'h40, 32'd21, 0, 1); chk("R3 data range miss", ext_trig, 1'b0);
    bus(0, 0, 1, 32'h44, 32'd15, 0, 1); chk("R3 address part misses", ext_trig, 1'b0);
  endtask

  task automatic t_and();
    clear_slots();
    cfg(2, 1, 32'h500); cfg(2, 3, 32'hAB);
    cfg(2, 0, EN | DBUS | A_EQ | NWR | HALT);
    bus(0, 0, 1, 32'h500, 0, 0, 1); chk("R4 write to address", halt_req, 1'b1);
    bus(0, 0, 1, 32'h500, 0, 1, 0); chk("R4 read to address", halt_req, 1'b0);
    bus(0, 0, 1, 32'h504, 0, 0, 1); chk("R4 write elsewhere", halt_req, 1'b0);
    cfg(2, 0, EN | DBUS | A_EQ | D_EQ | NWR | HALT);
    bus(0, 0, 1, 32'h500, 32'hAB, 0, 1); chk("R4 write of value", halt_req, 1'b1);
    bus(0, 0, 1, 32'h500, 32'hAC, 0, 1); chk("R4 write of other value", halt_req, 1'b0);
    cfg(2, 0, EN | DBUS | NRD | NWR | HALT);
    bus(0, 0, 1, 32'h0, 0, 1, 0); chk("R4 read alone fails rd+wr", halt_req, 1'b0);
  endtask

  task automatic t_ibus_ignore();
    clear_slots();
    cfg(0, 1, 32'h80); cfg(0, 3, 32'h1234);
    cfg(0, 0, EN | A_EQ | D_EQ | NRD | NWR | ARMONLY | EXT);
    bus(1, 32'h80, 0, 0, 32'h0, 0, 0);
    chk("R5 instr slot ignores data/rd/wr/armed", ext_trig, 1'b1);
    bus(0, 0, 1, 32'h80, 32'h1234, 1, 1);
    chk("R5 instr slot blind to data bus", ext_trig, 1'b0);
  endtask

  task automatic t_sample();
    clear_slots();
    cfg(0, 1, 32'h90);
    cfg(0, 0, EN | A_EQ | EXT | SAMP);
    bus(1, 32'h90, 0, 0, 0, 0, 0);
    chk("R6 instr slot fired", ext_trig, 1'b1);
    chk("R6 instr slot gives no sample", trace_sample, 1'b0);
    cfg(1, 1, 32'h90);
    cfg(1, 0, EN | DBUS | A_EQ | SAMP);
    bus(0, 0, 1, 32'h90, 0, 1, 0);
    chk("R6 data slot sample strobe", trace_sample, 1'b1);
    idle();
    chk("R10 sample is one cycle", trace_sample, 1'b0);
  endtask

  task automatic t_arm();
    clear_slots();
    cfg(0, 1, 32'hA00);
    cfg(0, 0, EN | DBUS | A_EQ | ARM);
    cfg(1, 1, 32'hB00);
    cfg(1, 0, EN | DBUS | A_EQ | ARMONLY | HALT);
    cfg(2, 1, 32'hC00);
    cfg(2, 0, EN | DBUS | A_EQ | ARM | ARMONLY | EXT);
    bus(0, 0, 1, 32'hB00, 0, 1, 0); chk("R7 B before A ignored", halt_req, 1'b0);
    bus(0, 0, 1, 32'hC00, 0, 1, 0); chk("R7 armed-only slot cannot self-arm", ext_trig, 1'b0);
    bus(0, 0, 1, 32'hA00, 0, 1, 0); chk("R7 arming cycle itself quiet", halt_req, 1'b0);
    bus(0, 0, 1, 32'hB00, 0, 1, 0); chk("R7 B after A fires", halt_req, 1'b1);
    idle(); idle();
    bus(0, 0, 1, 32'hB00, 0, 1, 0); chk("R8 armed flag sticky", halt_req, 1'b1);
    cfg(3, 2, 32'h1);
    bus(0, 0, 1, 32'hB00, 0, 1, 0); chk("R8 config write clears armed", halt_req, 1'b0);
  endtask

  task automatic t_trace();
    clear_slots();
    cfg(0, 1, 32'h700); cfg(0, 0, EN | A_EQ | TON);
    cfg(1, 1, 32'h700); cfg(1, 0, EN | DBUS | A_EQ | TOFF);
    bus(1, 32'h700, 0, 0, 0, 0, 0); chk("R9 trace on", trace_en, 1'b1);
    idle(); idle(); chk("R9 trace holds", trace_en, 1'b1);
    bus(0, 0, 1, 32'h700, 0, 1, 0); chk("R9 trace off", trace_en, 1'b0);
    bus(1, 32'h700, 0, 0, 0, 0, 0); chk("R9 trace on again", trace_en, 1'b1);
    bus(1, 32'h700, 1, 32'h700, 0, 1, 0); chk("R9 off wins over on", trace_en, 1'b0);
  endtask

  task automatic t_or();
    clear_slots();
    cfg(0, 1, 32'h10); cfg(0, 0, EN | A_EQ | HALT);
    cfg(1, 1, 32'h20); cfg(1, 0, EN | DBUS | A_EQ | EXT);
    cfg(2, 1, 32'h20); cfg(2, 0, EN | DBUS | A_EQ | HALT);
    bus(1, 32'h10, 1, 32'h20, 0, 1, 0);
    chk("R10 halt from two slots", halt_req, 1'b1);
    chk("R10 ext with halt", ext_trig, 1'b1);
    bus(1, 32'h10, 0, 0, 0, 0, 0); chk("R10 back-to-back halt 1", halt_req, 1'b1);
    chk("R10 ext gone", ext_trig, 1'b0);
    bus(1, 32'h10, 0, 0, 0, 0, 0); chk("R10 back-to-back halt 2", halt_req, 1'b1);
    idle(); chk("R10 halt drops", halt_req, 1'b0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_eq();
    t_range();
    t_and();
    t_ibus_ignore();
    t_sample();
    t_arm();
    t_trace();
    t_or();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule